// File: doc/BRIEF.md
# Way-Pointer-Directed Instruction Cache

This block is a set-associative instruction cache with two ways to serve a fetch. A tag-checked fetch reads the tag, valid bit and data word of every way in parallel, compares the stored tags with the fetch address and returns the matching word. It also returns the index of the way that matched, so that logic outside the cache can keep that index for later use. A directed fetch carries a way index supplied by the requester. It enables only that way's data array, reads no tags, does no comparison and returns the word at that way's line for the fetch's set and word offset.

The cache contents change only when a line is refilled after a miss. An index recorded from an earlier hit therefore stays correct until the next miss. Every miss drives a single-cycle pulse that tells the outside world to discard all recorded way indices. A miss fetches the whole line from the next-level memory in one beat and writes it into a round-robin victim way of the set. The cache then repeats the fetch as a tag-checked access, which hits. Per-way tag and data enable outputs show exactly which arrays were read in each cycle.

The default geometry is 16 KB, four ways, 32-byte lines and 32-bit instruction words. That gives 128 sets, a 20-bit tag, a 7-bit set index (address bits 11:5) and a 3-bit word offset (address bits 4:2).

Top module: `wpic_cache`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, miss_pulse, mem_req and every way enable are 0. All lines are invalid, so the first tag-checked fetch to any address misses.
- R2: A tag-checked fetch (req_directed=0) accepted in cycle N drives way_tag_en and way_data_en to all ones during cycle N. Its outcome appears in cycle N+1.
- R3: A tag-checked fetch that hits gives rsp_valid=1, rsp_tag_hit=1 and miss_pulse=0 in cycle N+1. rsp_data is the word at the fetch address, and rsp_way is the index of the single way that holds the line.
- R4: A tag-checked fetch that misses gives miss_pulse=1 for exactly one cycle (N+1), with rsp_valid=0 and req_ready=0 in that cycle.
- R5: From cycle N+2 after a miss, mem_req stays 1 with mem_line_addr equal to fetch address bits 31:5 until mem_ack is seen. During that time no data array is read and no response is given. Word k of the line is carried on mem_line bits 32k+31 to 32k.
- R6: With mem_ack sampled at the end of cycle M, the line is written and cycle M+1 is a tag-checked replay with all enables at 1. In cycle M+2 the fetch is answered with rsp_tag_hit=1 and the refilled word.
- R7: The victim way is chosen by a per-set round-robin counter that starts at 0 and advances on each refill of that set. Successive refills of one set use ways 0, 1, 2, 3, 0, and so on, and sets do not affect each other.
- R8: A directed fetch (req_directed=1, req_way=w) drives way_data_en to 1<<w and way_tag_en to 0 during cycle N. In cycle N+1 it gives rsp_valid=1, rsp_tag_hit=0, rsp_way=w, no miss_pulse, and the word of way w's line at the fetch's set and word offset, whatever the fetch tag is. Naming an invalid line is a protocol error.
- R9: While fetches are served without a miss, req_ready stays 1 in the response cycle, so one fetch per cycle is accepted and answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Cache can accept a fetch this cycle |
| req_addr | input | 32 | Byte address of the fetch |
| req_directed | input | 1 | 1 = directed fetch through req_way, 0 = tag-checked fetch |
| req_way | input | 2 | Way index used by a directed fetch |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Instruction word |
| rsp_tag_hit | output | 1 | Response came from a successful tag comparison |
| rsp_way | output | 2 | Way that supplied the word |
| miss_pulse | output | 1 | Single-cycle pulse on every miss |
| mem_req | output | 1 | Line refill requested |
| mem_line_addr | output | 27 | Line address of the refill |
| mem_ack | input | 1 | Refill line present on mem_line |
| mem_line | input | 256 | Refill line, word k in bits 32k+31 to 32k |
| way_tag_en | output | 4 | Per-way tag array read enable |
| way_data_en | output | 4 | Per-way data array read enable |

## Verification
Each result has a fixed due cycle. Enables are due in the cycle the fetch is presented. The hit or directed response, or the miss pulse, is due one cycle later. mem_req is due from the second cycle after acceptance and stays up for a random 0 to 3 extra cycles before mem_ack. The replay enables are due one cycle after mem_ack, and the refilled response one cycle after that. The bench drives on the falling edge and samples 1 ns later, walking the cycles one edge at a time, so every comparison lands exactly on the cycle where its result is due. A reference model of tags, valid bits and round-robin counters provides the expected way, word and hit/miss outcome.

// File: rtl/wpic_pkg.sv
package wpic_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOK   = 2'd1,
      ST_FILL   = 2'd2,
      ST_REPLAY = 2'd3
   } wpic_state_e;
endpackage

// File: rtl/wpic_way_bank.sv
module wpic_way_bank #(
   parameter int SETS       = 128,
   parameter int LINE_WORDS = 8,
   parameter int WORD_W     = 32,
   parameter int TAG_W      = 20,
   parameter int IDX_W      = 7,
   parameter int WOFF_W     = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tag_en,
   input  logic                         data_en,
   input  logic [IDX_W-1:0]             rd_idx,
   input  logic [WOFF_W-1:0]            rd_woff,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic [LINE_WORDS*WORD_W-1:0] wr_line,
   output logic [TAG_W-1:0]             rd_tag,
   output logic                         rd_valid,
   output logic [WORD_W-1:0]            rd_word,
   output logic                         cur_valid
);
   localparam int DEPTH = SETS * LINE_WORDS;

   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_mem [SETS];
   logic [WORD_W-1:0] dat_mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (wr_en)  vld_q[wr_idx] <= 1'b1;
         if (tag_en) rd_valid      <= vld_q[rd_idx];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en)  tag_mem[wr_idx] <= wr_tag;
      if (tag_en) rd_tag          <= tag_mem[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int k = 0; k < LINE_WORDS; k++) begin
            dat_mem[{wr_idx, WOFF_W'(k)}] <= wr_line[k*WORD_W +: WORD_W];
         end
      end
      if (data_en) rd_word <= dat_mem[{rd_idx, rd_woff}];
   end

   assign cur_valid = vld_q[rd_idx];
endmodule

// File: rtl/wpic_hit_sel.sv
module wpic_hit_sel #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   parameter int WAY_W = 2
) (
   input  logic [TAG_W-1:0] tags [WAYS],
   input  logic [WAYS-1:0]  valids,
   input  logic [TAG_W-1:0] cmp_tag,
   output logic [WAYS-1:0]  hit_vec,
   output logic             hit_any,
   output logic [WAY_W-1:0] hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valids[w] && (tags[w] == cmp_tag);
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
      end
   end

   assign hit_any = |hit_vec;
endmodule

// File: rtl/wpic_victim_rr.sv
module wpic_victim_rr #(
   parameter int SETS  = 128,
   parameter int IDX_W = 7,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             advance,
   output logic [WAY_W-1:0] victim
);
   logic [WAY_W-1:0] ctr_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) ctr_q[s] <= '0;
      end else if (advance) begin
         ctr_q[idx] <= ctr_q[idx] + 1'b1;
      end
   end

   assign victim = ctr_q[idx];
endmodule

// File: rtl/wpic_cache.sv
module wpic_cache
   import wpic_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int CACHE_BYTES = 16384,
   parameter int WAYS        = 4,
   parameter int LINE_BYTES  = 32
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   output logic                                   req_ready,
   input  logic [ADDR_W-1:0]                      req_addr,
   input  logic                                   req_directed,
   input  logic [$clog2(WAYS)-1:0]                req_way,
   output logic                                   rsp_valid,
   output logic [WORD_W-1:0]                      rsp_data,
   output logic                                   rsp_tag_hit,
   output logic [$clog2(WAYS)-1:0]                rsp_way,
   output logic                                   miss_pulse,
   output logic                                   mem_req,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_line_addr,
   input  logic                                   mem_ack,
   input  logic [LINE_BYTES*8-1:0]                mem_line,
   output logic [WAYS-1:0]                        way_tag_en,
   output logic [WAYS-1:0]                        way_data_en
);
   localparam int WAY_W      = $clog2(WAYS);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
   localparam int SETS       = CACHE_BYTES / (LINE_BYTES * WAYS);
   localparam int BOFF_W     = $clog2(WORD_BYTES);
   localparam int WOFF_W     = $clog2(LINE_WORDS);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int IDX_W      = $clog2(SETS);
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
   localparam int LINE_W     = LINE_BYTES * 8;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_chk_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if ((1 << IDX_W) != SETS || SETS < 2) begin : g_chk_sets
      $error("geometry must give a power-of-two set count");
   end
   if ((WORD_W % 8) != 0 || (1 << WOFF_W) != LINE_WORDS || LINE_WORDS < 2) begin : g_chk_line
      $error("line must hold a power-of-two number of whole words");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("address too narrow for the geometry");
   end

   wpic_state_e state_q, state_d;

   logic [ADDR_W-1:0] lk_addr_q;
   logic              lk_dir_q;
   logic [WAY_W-1:0]  lk_way_q;

   logic              accept, in_look, in_fill, in_replay;
   logic              tag_rd, dir_rd, fill_wr, served;
   logic [ADDR_W-1:0] rd_addr;
   logic [IDX_W-1:0]  rd_idx, lk_idx;
   logic [WOFF_W-1:0] rd_woff;
   logic [TAG_W-1:0]  lk_tag;

   logic [TAG_W-1:0]  bank_tag   [WAYS];
   logic [WORD_W-1:0] bank_word  [WAYS];
   logic              bank_rdv   [WAYS];
   logic              bank_cur   [WAYS];
   logic [WAYS-1:0]   rdv_vec, cur_vec, hit_vec;
   logic              hit_any;
   logic [WAY_W-1:0]  hit_way, victim;

   assign in_look   = (state_q == ST_LOOK);
   assign in_fill   = (state_q == ST_FILL);
   assign in_replay = (state_q == ST_REPLAY);

   assign accept  = req_valid && req_ready;
   assign rd_addr = in_replay ? lk_addr_q : req_addr;
   assign rd_idx  = rd_addr[OFF_W +: IDX_W];
   assign rd_woff = rd_addr[BOFF_W +: WOFF_W];
   assign lk_idx  = lk_addr_q[OFF_W +: IDX_W];
   assign lk_tag  = lk_addr_q[ADDR_W-1 -: TAG_W];

   assign tag_rd  = (accept && !req_directed) || in_replay;
   assign dir_rd  = accept && req_directed;
   assign fill_wr = in_fill && mem_ack;

   assign way_tag_en  = {WAYS{tag_rd}};
   assign way_data_en = tag_rd ? {WAYS{1'b1}}
                      : dir_rd ? (WAYS'(1) << req_way)
                      : '0;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      wpic_way_bank #(
         .SETS       (SETS),
         .LINE_WORDS (LINE_WORDS),
         .WORD_W     (WORD_W),
         .TAG_W      (TAG_W),
         .IDX_W      (IDX_W),
         .WOFF_W     (WOFF_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .tag_en    (way_tag_en[w]),
         .data_en   (way_data_en[w]),
         .rd_idx    (rd_idx),
         .rd_woff   (rd_woff),
         .wr_en     (fill_wr && (victim == WAY_W'(w))),
         .wr_idx    (lk_idx),
         .wr_tag    (lk_tag),
         .wr_line   (mem_line),
         .rd_tag    (bank_tag[w]),
         .rd_valid  (bank_rdv[w]),
         .rd_word   (bank_word[w]),
         .cur_valid (bank_cur[w])
      );
      assign rdv_vec[w] = bank_rdv[w];
      assign cur_vec[w] = bank_cur[w];
   end

   wpic_hit_sel #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .WAY_W (WAY_W)
   ) u_hit (
      .tags    (bank_tag),
      .valids  (rdv_vec),
      .cmp_tag (lk_tag),
      .hit_vec (hit_vec),
      .hit_any (hit_any),
      .hit_way (hit_way)
   );

   wpic_victim_rr #(
      .SETS  (SETS),
      .IDX_W (IDX_W),
      .WAY_W (WAY_W)
   ) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (lk_idx),
      .advance (fill_wr),
      .victim  (victim)
   );

   assign served      = in_look && (lk_dir_q || hit_any);
   assign miss_pulse  = in_look && !lk_dir_q && !hit_any;
   assign rsp_valid   = served;
   assign rsp_tag_hit = in_look && !lk_dir_q && hit_any;
   assign rsp_way     = lk_dir_q ? lk_way_q : hit_way;
   assign rsp_data    = bank_word[rsp_way];
   assign req_ready   = (state_q == ST_IDLE) || served;

   assign mem_req       = in_fill;
   assign mem_line_addr = lk_addr_q[ADDR_W-1:OFF_W];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept) state_d = ST_LOOK;
         ST_LOOK: begin
            if (miss_pulse)  state_d = ST_FILL;
            else if (accept) state_d = ST_LOOK;
            else             state_d = ST_IDLE;
         end
         ST_FILL:   if (mem_ack) state_d = ST_REPLAY;
         ST_REPLAY: state_d = ST_LOOK;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         lk_addr_q <= '0;
         lk_dir_q  <= 1'b0;
         lk_way_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            lk_addr_q <= req_addr;
            lk_dir_q  <= req_directed;
            lk_way_q  <= req_way;
         end else if (in_replay) begin
            lk_dir_q  <= 1'b0;
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^{lk_addr_q[BOFF_W-1:0], req_addr[BOFF_W-1:0]};

   AST_DIR_LINE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dir_rd |-> cur_vec[req_way]) else $error("directed fetch names an invalid line"); // R8
   AST_DIR_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      dir_rd |-> ($onehot(way_data_en) && way_tag_en == '0)) else $error("directed fetch enabled extra arrays"); // R8
   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_look && !lk_dir_q) |-> $onehot0(hit_vec)) else $error("line present in two ways"); // R3
   AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |=> (!miss_pulse && mem_req)) else $error("miss pulse not followed by refill"); // R4
   AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |-> (!req_ready && !rsp_valid)) else $error("miss cycle accepted or answered"); // R4
   AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (way_data_en == '0 && !rsp_valid)) else $error("array activity during refill"); // R5
   AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      in_replay |=> (rsp_valid && rsp_tag_hit)) else $error("replay after refill missed"); // R6
endmodule

// File: tb/wpic_cache_tb.sv
`timescale 1ns/1ps
module wpic_cache_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [31:0]  req_addr = '0;
   logic         req_directed = 1'b0;
   logic [1:0]   req_way = '0;
   logic         rsp_valid;
   logic [31:0]  rsp_data;
   logic         rsp_tag_hit;
   logic [1:0]   rsp_way;
   logic         miss_pulse;
   logic         mem_req;
   logic [26:0]  mem_line_addr;
   logic         mem_ack = 1'b0;
   logic [255:0] mem_line = '0;
   logic [3:0]   way_tag_en;
   logic [3:0]   way_data_en;

   int n_chk = 0;
   int n_bad = 0;

   logic [19:0] m_tag [128][4];
   bit          m_val [128][4];
   logic [1:0]  m_rr  [128];

   always #2 clk = ~clk;

   wpic_cache u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_directed(req_directed), .req_way(req_way),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag_hit(rsp_tag_hit),
      .rsp_way(rsp_way), .miss_pulse(miss_pulse), .mem_req(mem_req),
      .mem_line_addr(mem_line_addr), .mem_ack(mem_ack), .mem_line(mem_line),
      .way_tag_en(way_tag_en), .way_data_en(way_data_en)
   );

   function automatic logic [31:0] mw(input logic [31:0] a);
      logic [31:0] wa;
      wa = {2'b00, a[31:2]};
      return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] mk_addr(input logic [19:0] t, input logic [6:0] i, input logic [2:0] o);
      return {t, i, o, 2'b00};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic fetch(input logic [31:0] a, input bit dir, input logic [1:0] w);
      logic [6:0]  idx;
      logic [19:0] tg;
      bit          found;
      logic [1:0]  hw;
      int          lat;
      logic [1:0]  vic;
      idx = a[11:5];
      tg  = a[31:12];
      found = 1'b0;
      hw = '0;
      for (int k = 0; k < 4; k++) begin
         if (m_val[idx][k] && m_tag[idx][k] == tg) begin
            found = 1'b1;
            hw = 2'(k);
         end
      end
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_directed = dir; req_way = w;
      #1;
      chk(req_ready == 1'b1, "R9", "ready before fetch", 64'(req_ready), 64'd1);
      if (dir) begin
         chk(way_data_en == (4'b1 << w) && way_tag_en == 4'h0, "R8", "directed enables",
             64'({way_tag_en, way_data_en}), 64'({4'h0, 4'b1 << w}));
      end else begin
         chk(way_tag_en == 4'hF && way_data_en == 4'hF, "R2", "checked enables",
             64'({way_tag_en, way_data_en}), 64'hFF);
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      if (dir) begin
         chk(rsp_valid && !rsp_tag_hit && !miss_pulse && rsp_way == w, "R8", "directed flags",
             64'({rsp_valid, rsp_tag_hit, miss_pulse, rsp_way}), 64'({3'b100, w}));
         chk(rsp_data == mw(mk_addr(m_tag[idx][w], idx, a[4:2])), "R8", "directed word",
             64'(rsp_data), 64'(mw(mk_addr(m_tag[idx][w], idx, a[4:2]))));
      end else if (found) begin
         chk(rsp_valid && rsp_tag_hit && !miss_pulse && rsp_way == hw, "R3", "hit flags",
             64'({rsp_valid, rsp_tag_hit, miss_pulse, rsp_way}), 64'({3'b110, hw}));
         chk(rsp_data == mw(a), "R3", "hit word", 64'(rsp_data), 64'(mw(a)));
      end else begin
         chk(miss_pulse && !rsp_valid && !req_ready, "R4", "miss cycle",
             64'({miss_pulse, rsp_valid, req_ready}), 64'b100);
         @(negedge clk);
         #1;
         chk(mem_req && mem_line_addr == a[31:5] && !miss_pulse, "R5", "refill request",
             64'({miss_pulse, mem_req, mem_line_addr}), 64'({2'b01, a[31:5]}));
         lat = $urandom_range(0, 3);
         for (int c = 0; c < lat; c++) begin
            @(negedge clk);
            #1;
            chk(mem_req && way_data_en == 4'h0 && !rsp_valid, "R5", "refill wait",
                64'({mem_req, rsp_valid, way_data_en}), 64'h20);
         end
         mem_ack = 1'b1;
         for (int k = 0; k < 8; k++) mem_line[k*32 +: 32] = mw({a[31:5], 3'(k), 2'b00});
         @(posedge clk);
         @(negedge clk);
         mem_ack = 1'b0;
         #1;
         chk(way_tag_en == 4'hF && way_data_en == 4'hF && !mem_req, "R6", "replay enables",
             64'({mem_req, way_tag_en, way_data_en}), 64'hFF);
         @(posedge clk);
         @(negedge clk);
         #1;
         vic = m_rr[idx];
         chk(rsp_valid && rsp_tag_hit && rsp_data == mw(a), "R6", "refilled word",
             64'({rsp_valid, rsp_tag_hit, rsp_data}), 64'({2'b11, mw(a)}));
         chk(rsp_way == vic, "R7", "victim way", 64'(rsp_way), 64'(vic));
         m_tag[idx][vic] = tg;
         m_val[idx][vic] = 1'b1;
         m_rr[idx] = vic + 2'd1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [1:0] seq_exp [5];
      logic [31:0] a0, a1;
      void'($urandom(32'd20240611));
      for (int s = 0; s < 128; s++) begin
         m_rr[s] = '0;
         for (int k = 0; k < 4; k++) begin
            m_val[s][k] = 1'b0;
            m_tag[s][k] = '0;
         end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(req_ready && !rsp_valid && !miss_pulse && !mem_req && way_tag_en == 0 && way_data_en == 0,
          "R1", "reset outputs",
          64'({req_ready, rsp_valid, miss_pulse, mem_req, way_tag_en, way_data_en}), 64'h800);

      // R1 / R4: first fetch after reset misses
      fetch(mk_addr(20'h00ABC, 7'd40, 3'd5), 1'b0, 2'd0);
      // R3: same line, other word, hits
      fetch(mk_addr(20'h00ABC, 7'd40, 3'd2), 1'b0, 2'd0);

      // R7: five refills of one set walk the ways in order
      seq_exp = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
      for (int t = 0; t < 5; t++) begin
         fetch(mk_addr(20'h00100 + 20'(t), 7'd9, 3'(t)), 1'b0, 2'd0);
         chk(m_rr[9] == seq_exp[t] + 2'd1, "R7", "round-robin order",
             64'(m_rr[9]), 64'(seq_exp[t] + 2'd1));
      end
      // R7: other set untouched by those refills
      chk(m_rr[40] == 2'd1, "R7", "independent set counter", 64'(m_rr[40]), 64'd1);
      fetch(mk_addr(20'h00777, 7'd40, 3'd0), 1'b0, 2'd0);

      // R8: directed fetch with a foreign tag reads the named way without comparing
      fetch(mk_addr(20'hFFFFF, 7'd9, 3'd6), 1'b1, 2'd2);
      fetch(mk_addr(20'h00104, 7'd9, 3'd1), 1'b1, 2'd0);

      // R9: back-to-back hits, one per cycle
      a0 = mk_addr(20'h00102, 7'd9, 3'd3);
      a1 = mk_addr(20'h00ABC, 7'd40, 3'd7);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a0; req_directed = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_addr = a1;
      #1;
      chk(rsp_valid && rsp_data == mw(a0) && rsp_way == 2'd2, "R9", "first of pair",
          64'({rsp_valid, rsp_way, rsp_data}), 64'({1'b1, 2'd2, mw(a0)}));
      chk(req_ready == 1'b1, "R9", "ready in response cycle", 64'(req_ready), 64'd1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(rsp_valid && rsp_data == mw(a1) && rsp_way == 2'd0, "R9", "second of pair",
          64'({rsp_valid, rsp_way, rsp_data}), 64'({1'b1, 2'd0, mw(a1)}));

      // random mix of tag-checked and directed fetches over a small address pool
      for (int n = 0; n < 1500; n++) begin
         logic [6:0]  ri;
         logic [19:0] rt;
         logic [2:0]  ro;
         int          nv;
         logic [1:0]  pick;
         ri = 7'($urandom_range(0, 3));
         rt = 20'h00200 + 20'($urandom_range(0, 5));
         ro = 3'($urandom_range(0, 7));
         nv = 0;
         for (int k = 0; k < 4; k++) if (m_val[ri][k]) nv++;
         if (nv > 0 && $urandom_range(0, 2) == 0) begin
            pick = 2'($urandom_range(0, 3));
            while (!m_val[ri][pick]) pick = pick + 2'd1;
            fetch(mk_addr(rt, ri, ro), 1'b1, pick);
         end else begin
            fetch(mk_addr(rt, ri, ro), 1'b0, 2'd0);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule